// File: doc/BRIEF.md
# Configuration Load Policy Gate

This block sits between a configuration packet port and the configuration memory write path, and decides for each packet whether it may be written. Every packet carries two tags: whether its payload is encrypted and whether it arrives over the external load path or from the running application through the internal access path. With each packet come two verdicts from an authentication engine outside the block: a match result from the 256-bit keyed MAC and a pass result from the 32-bit integrity check. A one-time secure-only fuse level and a full device-clear input complete the inputs.

A session is opened by a one-cycle start pulse. Packets are offered with a valid/ready handshake, and the accept or reject verdict shows up one cycle after the handshake. The first accepted external packet fixes the session's encryption mode. That mode is kept until device clear. Any rejection sets a sticky cause bit and aborts the session until the next start pulse. Once encrypted data has been accepted, configuration readback is locked until device clear.

Top module: `cfg_load_gate`

## Requirements
- R1: After reset or device clear, `rdbk_en` is 1, `err_status` is 0, `pkt_ready` is 0 and `dec_valid` is 0. A device clear overrides a start pulse given in the same cycle.
- R2: `pkt_ready` is 1 only while a session is open. A handshake (`pkt_valid` and `pkt_ready` high at a clock edge) produces `dec_valid` = 1 in the next cycle, with `dec_accept` giving the verdict. Without a handshake, `dec_valid` is 0.
- R3: While `fuse_secure_only` is 1, every plain packet (`pkt_enc` = 0) is rejected, whatever its path, and `err_status` bit 0 is set.
- R4: The first accepted external packet (`pkt_internal` = 0) after device clear latches the mode (encrypted or plain). That mode survives later start pulses. A later external packet of the other kind is rejected and sets `err_status` bit 1.
- R5: Internal packets are exempt from the mix rule and never latch the mode.
- R6: An encrypted packet is accepted only if `pkt_mac_ok` = 1. A passing 32-bit check with a failing MAC is rejected and sets `err_status` bit 2.
- R7: With `PLAIN_CHECK` = 1, a plain packet whose `pkt_crc_ok` = 0 is rejected and sets `err_status` bit 3.
- R8: A rejection sets exactly one cause bit. Priority is fuse (bit 0) over mix (bit 1) over MAC (bit 2) or integrity (bit 3).
- R9: After a rejection, `pkt_ready` is 0 from the next cycle until the next start pulse.
- R10: `rdbk_en` drops in the cycle that `dec_accept` first shows an accepted encrypted packet. It stays 0 through later start pulses until device clear.
- R11: `err_status` bits are sticky: they accumulate across sessions and clear only on reset or device clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_clear | input | 1 | Full device clear: drops session, mode, lock and errors |
| sess_start | input | 1 | One-cycle session start pulse |
| fuse_secure_only | input | 1 | Secure-only fuse level |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Gate can take a packet (session open) |
| pkt_enc | input | 1 | Packet payload is encrypted |
| pkt_internal | input | 1 | Packet came over the internal access path |
| pkt_mac_ok | input | 1 | Keyed 256-bit MAC matched |
| pkt_crc_ok | input | 1 | 32-bit integrity check passed |
| dec_valid | output | 1 | Verdict for the previous handshake is present |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |
| rdbk_en | output | 1 | Configuration readback allowed |
| err_status | output | 4 | Sticky causes: bit0 fuse, bit1 mix, bit2 MAC, bit3 integrity |

## Verification
The bench builds the gate with its default `PLAIN_CHECK` = 1. That setting brings the integrity-failure cause on plain packets within reach, alongside the fuse, mix and MAC causes. With all four causes live, the priority order can be exercised by packets that break two rules at once, such as a plain external packet under the fuse after an encrypted mode is latched. The directed scenarios also walk the mode and readback lock across several start pulses, to show that only device clear releases them.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;

    localparam int ERR_W    = 4;
    localparam int ERR_FUSE = 0;
    localparam int ERR_MIX  = 1;
    localparam int ERR_MAC  = 2;
    localparam int ERR_CRC  = 3;

    typedef enum logic [1:0] {
        SS_IDLE  = 2'd0,
        SS_OPEN  = 2'd1,
        SS_ABORT = 2'd2
    } sess_e;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_ENC   = 2'd1,
        MODE_PLAIN = 2'd2
    } mode_e;

    typedef struct packed {
        logic enc;
        logic internal;
        logic mac_ok;
        logic crc_ok;
    } pkt_t;

    typedef struct packed {
        logic             accept;
        logic [ERR_W-1:0] cause;
    } verdict_t;

    function automatic logic [ERR_W-1:0] cause_bit(input int idx);
        logic [ERR_W-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    // Rule order fixes the priority: fuse, then mix, then authentication.
    function automatic verdict_t judge(input pkt_t p, input mode_e m,
                                       input logic fuse, input logic plain_good);
        verdict_t r;
        logic     clash;
        clash    = !p.internal && (m != MODE_NONE) && ((m == MODE_ENC) != p.enc);
        r.accept = 1'b0;
        r.cause  = '0;
        if (fuse && !p.enc)             r.cause = cause_bit(ERR_FUSE);
        else if (clash)                 r.cause = cause_bit(ERR_MIX);
        else if (p.enc && !p.mac_ok)    r.cause = cause_bit(ERR_MAC);
        else if (!p.enc && !plain_good) r.cause = cause_bit(ERR_CRC);
        else                            r.accept = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/cfg_rule_eval.sv
module cfg_rule_eval
    import cfg_gate_pkg::*;
#(
    parameter bit PLAIN_CHECK = 1'b1
) (
    input  pkt_t     pkt,
    input  mode_e    mode,
    input  logic     fuse,
    output verdict_t vd
);
    logic plain_good;

    generate
        if (PLAIN_CHECK) begin : g_crc
            assign plain_good = pkt.crc_ok;
        end else begin : g_nocrc
            logic unused_crc;
            assign unused_crc = pkt.crc_ok;
            assign plain_good = 1'b1;
        end
    endgenerate

    always_comb begin
        vd = judge(pkt, mode, fuse, plain_good);
    end
endmodule

// File: rtl/cfg_sess_ctrl.sv
module cfg_sess_ctrl
    import cfg_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     dev_clear,
    input  logic     sess_start,
    input  logic     take,
    input  pkt_t     pkt,
    input  verdict_t vd,
    output logic     open_o,
    output mode_e    mode_o
);
    sess_e st_q;
    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst || dev_clear) begin
            st_q   <= SS_IDLE;
            mode_q <= MODE_NONE;
        end else begin
            if (sess_start)
                st_q <= SS_OPEN;
            else if (take && !vd.accept)
                st_q <= SS_ABORT;
            if (take && vd.accept && !pkt.internal && mode_q == MODE_NONE)
                mode_q <= pkt.enc ? MODE_ENC : MODE_PLAIN;
        end
    end

    assign open_o = (st_q == SS_OPEN);
    assign mode_o = mode_q;

    // R4: a latched mode holds until device clear
    assert_mode_held_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_NONE) && !dev_clear |=> mode_q == $past(mode_q));

    // R5: internal packets never latch the mode
    assert_internal_no_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NONE) && take && pkt.internal && !dev_clear |=> mode_q == MODE_NONE);
endmodule

// File: rtl/cfg_lock_status.sv
module cfg_lock_status
    import cfg_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dev_clear,
    input  logic             take,
    input  pkt_t             pkt,
    input  verdict_t         vd,
    output logic             dec_valid_o,
    output logic             dec_accept_o,
    output logic             lock_o,
    output logic [ERR_W-1:0] err_o
);
    logic             dv_q, da_q, lock_q;
    logic [ERR_W-1:0] err_q;

    always_ff @(posedge clk) begin
        if (rst || dev_clear) begin
            dv_q   <= 1'b0;
            da_q   <= 1'b0;
            lock_q <= 1'b0;
            err_q  <= '0;
        end else begin
            dv_q <= take;
            da_q <= take && vd.accept;
            if (take)
                err_q <= err_q | vd.cause;
            if (take && vd.accept && pkt.enc)
                lock_q <= 1'b1;
        end
    end

    assign dec_valid_o  = dv_q;
    assign dec_accept_o = da_q;
    assign lock_o       = lock_q;
    assign err_o        = err_q;

    // R10: readback lock is held until device clear
    assert_lock_held_R10: assert property (@(posedge clk) disable iff (rst)
        lock_q && !dev_clear |=> lock_q);

    // R11: error causes never drop without device clear
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        !dev_clear |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/cfg_load_gate.sv
module cfg_load_gate
    import cfg_gate_pkg::*;
#(
    parameter bit PLAIN_CHECK = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dev_clear,
    input  logic             sess_start,
    input  logic             fuse_secure_only,
    input  logic             pkt_valid,
    output logic             pkt_ready,
    input  logic             pkt_enc,
    input  logic             pkt_internal,
    input  logic             pkt_mac_ok,
    input  logic             pkt_crc_ok,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             rdbk_en,
    output logic [ERR_W-1:0] err_status
);
    pkt_t     pkt;
    mode_e    mode;
    verdict_t vd;
    logic     sess_open, take, lock;

    assign pkt.enc      = pkt_enc;
    assign pkt.internal = pkt_internal;
    assign pkt.mac_ok   = pkt_mac_ok;
    assign pkt.crc_ok   = pkt_crc_ok;

    assign pkt_ready = sess_open;
    assign take      = pkt_valid && sess_open;

    cfg_rule_eval #(.PLAIN_CHECK(PLAIN_CHECK)) u_rules (
        .pkt  (pkt),
        .mode (mode),
        .fuse (fuse_secure_only),
        .vd   (vd)
    );

    cfg_sess_ctrl u_sess (
        .clk        (clk),
        .rst        (rst),
        .dev_clear  (dev_clear),
        .sess_start (sess_start),
        .take       (take),
        .pkt        (pkt),
        .vd         (vd),
        .open_o     (sess_open),
        .mode_o     (mode)
    );

    cfg_lock_status u_stat (
        .clk          (clk),
        .rst          (rst),
        .dev_clear    (dev_clear),
        .take         (take),
        .pkt          (pkt),
        .vd           (vd),
        .dec_valid_o  (dec_valid),
        .dec_accept_o (dec_accept),
        .lock_o       (lock),
        .err_o        (err_status)
    );

    assign rdbk_en = !lock;

    // R2: a verdict appears only for the handshake one cycle earlier
    assert_dec_follows_take_R2: assert property (@(posedge clk) disable iff (rst)
        !dev_clear |=> dec_valid == $past(pkt_valid && pkt_ready));

    // R3: plain packets under the fuse are refused
    assert_fuse_rejects_R3: assert property (@(posedge clk) disable iff (rst)
        take && fuse_secure_only && !pkt_enc && !dev_clear |=> dec_valid && !dec_accept);

    // R6: an encrypted packet without a MAC match is refused
    assert_mac_required_R6: assert property (@(posedge clk) disable iff (rst)
        take && pkt_enc && !pkt_mac_ok && !dev_clear |=> !dec_accept);

    // R8: each refusal names exactly one cause
    assert_one_cause_R8: assert property (@(posedge clk) disable iff (rst)
        take |-> ($countones(vd.cause) == (vd.accept ? 0 : 1)));

    // R9: a refusal closes the port
    assert_abort_closes_R9: assert property (@(posedge clk) disable iff (rst)
        take && !vd.accept && !sess_start && !dev_clear |=> !pkt_ready);

    // R10: an accepted encrypted packet locks readback
    assert_enc_locks_R10: assert property (@(posedge clk) disable iff (rst)
        take && pkt_enc && vd.accept && !dev_clear |=> !rdbk_en);
endmodule

// File: tb/cfg_load_gate_tb_top.sv
module cfg_load_gate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_clear = 1'b0, sess_start = 1'b0, fuse = 1'b0;
    logic       pkt_valid = 1'b0, pkt_enc = 1'b0, pkt_internal = 1'b0;
    logic       pkt_mac_ok = 1'b0, pkt_crc_ok = 1'b0;
    logic       pkt_ready, dec_valid, dec_accept, rdbk_en;
    logic [3:0] err_status;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_load_gate #(.PLAIN_CHECK(1'b1)) dut_i (
        .clk(clk), .rst(rst), .dev_clear(dev_clear), .sess_start(sess_start),
        .fuse_secure_only(fuse), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_enc(pkt_enc), .pkt_internal(pkt_internal), .pkt_mac_ok(pkt_mac_ok),
        .pkt_crc_ok(pkt_crc_ok), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .rdbk_en(rdbk_en), .err_status(err_status)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic start_pulse();
        sess_start = 1'b1;
        @(posedge clk); @(negedge clk);
        sess_start = 1'b0;
    endtask

    task automatic clear_dev();
        dev_clear = 1'b1;
        @(posedge clk); @(negedge clk);
        dev_clear = 1'b0;
    endtask

    task automatic send(input logic enc, input logic intl, input logic mac,
                        input logic crc, input logic exp_acc, input logic [3:0] exp_err,
                        input string req);
        chk(pkt_ready == 1'b1, req, "ready before send", pkt_ready, 1);
        pkt_valid = 1'b1; pkt_enc = enc; pkt_internal = intl;
        pkt_mac_ok = mac; pkt_crc_ok = crc;
        @(posedge clk); @(negedge clk);
        pkt_valid = 1'b0;
        chk(dec_valid == 1'b1, req, "dec_valid", dec_valid, 1);
        chk(dec_accept == exp_acc, req, "dec_accept", dec_accept, exp_acc);
        chk(err_status == exp_err, req, "err_status", err_status, exp_err);
    endtask

    task automatic t_reset();
        chk(rdbk_en == 1'b1, "R1", "rdbk_en", rdbk_en, 1);
        chk(err_status == 4'h0, "R1", "err_status", err_status, 0);
        chk(pkt_ready == 1'b0, "R1", "ready idle", pkt_ready, 0);
        chk(dec_valid == 1'b0, "R1", "dec_valid", dec_valid, 0);
        pkt_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        pkt_valid = 1'b0;
        chk(dec_valid == 1'b0, "R2", "no verdict without session", dec_valid, 0);
    endtask

    task automatic t_plain_then_mix();
        clear_dev(); start_pulse();
        send(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, "R2");
        @(negedge clk);
        chk(dec_valid == 1'b0, "R2", "verdict one cycle only", dec_valid, 0);
        send(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, "R4");
        send(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2, "R4");
        chk(pkt_ready == 1'b0, "R9", "ready after reject", pkt_ready, 0);
        chk(rdbk_en == 1'b1, "R10", "rdbk after refused enc", rdbk_en, 1);
        start_pulse();
        send(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h2, "R4");
    endtask

    task automatic t_internal_and_lock();
        clear_dev();
        chk(err_status == 4'h0, "R11", "cleared by device clear", err_status, 0);
        chk(pkt_ready == 1'b0, "R1", "ready after clear", pkt_ready, 0);
        start_pulse();
        send(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, "R5");
        send(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, "R5");
        chk(rdbk_en == 1'b0, "R10", "rdbk after enc accept", rdbk_en, 0);
        send(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, "R5");
        send(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h2, "R4");
        start_pulse();
        chk(rdbk_en == 1'b0, "R10", "rdbk across start", rdbk_en, 0);
        chk(pkt_ready == 1'b1, "R9", "ready after new start", pkt_ready, 1);
        clear_dev();
        chk(rdbk_en == 1'b1, "R10", "rdbk after clear", rdbk_en, 1);
    endtask

    task automatic t_mac_crc();
        clear_dev(); start_pulse();
        send(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h4, "R6");
        chk(rdbk_en == 1'b1, "R6", "rdbk after mac fail", rdbk_en, 1);
        start_pulse();
        send(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hC, "R7");
        chk(err_status == 4'hC, "R11", "causes accumulate", err_status, 4'hC);
    endtask

    task automatic t_fuse();
        clear_dev(); fuse = 1'b1; start_pulse();
        send(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h1, "R3");
        start_pulse();
        send(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'h1, "R3");
        send(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h1, "R8");
        fuse = 1'b0;
    endtask

    task automatic t_clear_over_start();
        dev_clear = 1'b1; sess_start = 1'b1;
        @(posedge clk); @(negedge clk);
        dev_clear = 1'b0; sess_start = 1'b0;
        chk(pkt_ready == 1'b0, "R1", "clear beats start", pkt_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_then_mix();
        t_internal_and_lock();
        t_mac_crc();
        t_fuse();
        t_clear_over_start();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule